// File: doc/BRIEF.md
# Word-Streamed Byte Buffer Port

This block gives a host a 16-bit window into a small byte-organized transfer buffer. The host first loads a length in bytes, then issues one direction command (buffer read or buffer write). After that it streams 16-bit words through a write channel or a read channel, and never repeats the command. An internal byte pointer starts at zero and advances by two for every word moved. When the pointer reaches or passes the programmed length, the block emits a one-cycle end-of-transfer pulse. That pulse latches a sticky interrupt bit and a buffer-done flag.

Each 16-bit word holds one even and one odd buffer address. The upper byte is the even address and the lower byte is the following odd address. An odd length is rounded up to whole words, and the unused lower byte of the final write is not stored. Once the length is reached, further word accesses have no effect until the next command. Read data is prefetched from a synchronous RAM, so a read word is presented before the host takes it.

Both data directions use valid/ready. A write word is taken on any clock edge where `wr_valid` and `wr_ready` are both high. `wr_ready` drops only in a cycle that carries a command. A read word is taken on any edge where `rd_valid` and `rd_ready` are both high. After a read command, and after each word taken, `rd_valid` stays low for one cycle while the next word is fetched. The host may hold `rd_ready` high or low for any length of time. Data is neither lost nor duplicated under back-pressure.

Top module: `wordbuf_port`

## Requirements
- R1: Command code 0x40 selects buffer read and 0xC0 selects buffer write. Each of them resets the byte pointer to 0. Any other code on `cmd_we` leaves the direction and the pointer unchanged.
- R2: A byte length is taken from `cnt_wdata` on `cnt_we` and is used by the following transfer. Values above the buffer size (256) are clamped to 256.
- R3: Every word accepted during an active transfer advances the byte pointer by 2. One command serves any number of words.
- R4: Bits 15:8 of a data word map to the even byte address and bits 7:0 to the following odd address.
- R5: `eot_pulse` is high for exactly one cycle. That cycle follows the edge that accepted the word bringing the pointer to or past the length. A length of 0 makes the pulse follow the command edge itself.
- R6: `irq_status` bit 2 becomes 1 one cycle after `eot_pulse` and stays set. It clears on an `irq_we` edge with `irq_wdata` bit 2 equal to 1, and a 0 there has no effect. A simultaneous end-of-transfer wins over the clear. All other bits read 0.
- R7: `buf_done` is set together with the interrupt bit and is cleared by a valid command.
- R8: A transfer whose pointer never reaches the length produces no `eot_pulse` and changes neither `irq_status` nor `buf_done`.
- R9: After the length is reached, write words are accepted but do not modify the buffer. Read words present 0 with `rd_valid` high. The pointer does not move and no further end-of-transfer occurs.
- R10: For an odd length, the final write word stores only its upper (even) byte. The odd byte keeps its previous contents.
- R11: `rd_valid` is low outside read mode. It is low in the cycle after a read command and in the cycle after each accepted read word, and high otherwise in read mode.
- R12: `wr_ready` is low in any cycle in which `cmd_we` is high. A data word offered in that cycle is discarded.
- R13: After reset, `rd_valid`, `eot_pulse`, `buf_done` and `irq_status` are 0, and `wr_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_we | input | 1 | Load byte length strobe |
| cnt_wdata | input | 16 | Byte length |
| cmd_we | input | 1 | Command strobe |
| cmd_code | input | 8 | Command code (0x40 read, 0xC0 write) |
| wr_valid | input | 1 | Write word offered |
| wr_ready | output | 1 | Write word can be taken |
| wr_data | input | 16 | Write word (15:8 even byte, 7:0 odd byte) |
| rd_valid | output | 1 | Read word presented |
| rd_ready | input | 1 | Host takes read word |
| rd_data | output | 16 | Read word (15:8 even byte, 7:0 odd byte) |
| irq_we | input | 1 | Interrupt status write strobe |
| irq_wdata | input | 8 | Write-1-to-clear mask |
| irq_status | output | 8 | Interrupt status, bit 2 end-of-transfer |
| buf_done | output | 1 | Buffer transfer complete flag |
| eot_pulse | output | 1 | One-cycle end-of-transfer event |

## Verification
The end-of-transfer pulse is due one cycle after the accepting edge of the last word. The interrupt bit and `buf_done` are due one cycle after that. The RAM write takes effect on the accepting edge itself, and a read word shows up two edges after a command or an accepted read. The bench drives every input on the falling edge and samples on the falling edge that follows each of these counts. It first checks that the pulse is absent after the last word but one, then checks the interrupt bit is still 0 in the pulse cycle and 1 in the next. Read tasks wait for `rd_valid` only after first checking the one-cycle fetch bubble.

// File: rtl/wbp_pkg.sv
package wbp_pkg;
  typedef enum logic [1:0] {
    XF_IDLE  = 2'd0,
    XF_READ  = 2'd1,
    XF_WRITE = 2'd2
  } xfer_mode_e;

  localparam logic [7:0] CMD_BUF_RD = 8'h40;
  localparam logic [7:0] CMD_BUF_WR = 8'hC0;
endpackage

// File: rtl/wbp_ctrl.sv
module wbp_ctrl
  import wbp_pkg::*;
#(
  parameter int DEPTH = 256,
  parameter int CW    = $clog2(DEPTH) + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cnt_we,
  input  logic [15:0]     cnt_wdata,
  input  logic            cmd_we,
  input  logic [7:0]      cmd_code,
  input  logic            wr_fire,
  input  logic            rd_fire,
  output xfer_mode_e      mode,
  output logic [CW-1:0]   ptr,
  output logic            done,
  output logic            fetch_pend,
  output logic            eot,
  output logic            cmd_ok,
  output logic            we_even,
  output logic            we_odd
);
  logic [CW-1:0] count_q, ptr_q, ptr_nxt, cnt_clamped;
  logic          cmd_rd, cmd_wr, active, step, last;

  assign cmd_rd  = cmd_we && (cmd_code == CMD_BUF_RD);
  assign cmd_wr  = cmd_we && (cmd_code == CMD_BUF_WR);
  assign cmd_ok  = cmd_rd || cmd_wr;
  assign active  = (mode != XF_IDLE) && !done;
  assign step    = !cmd_we && active &&
                   (((mode == XF_READ) && rd_fire) || ((mode == XF_WRITE) && wr_fire));
  assign ptr_nxt = ptr_q + CW'(2);
  assign last    = (ptr_nxt >= count_q);
  assign cnt_clamped = (cnt_wdata > 16'(DEPTH)) ? CW'(DEPTH) : cnt_wdata[CW-1:0];

  assign we_even = step && (mode == XF_WRITE);
  assign we_odd  = we_even && ((ptr_q + CW'(1)) < count_q);
  assign ptr     = ptr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count_q    <= '0;
      ptr_q      <= '0;
      mode       <= XF_IDLE;
      done       <= 1'b0;
      eot        <= 1'b0;
      fetch_pend <= 1'b0;
    end else begin
      if (cnt_we) count_q <= cnt_clamped;
      if (cmd_ok) begin
        mode       <= cmd_rd ? XF_READ : XF_WRITE;
        ptr_q      <= '0;
        done       <= (count_q == '0);
        eot        <= (count_q == '0);
        fetch_pend <= cmd_rd;
      end else if (step) begin
        ptr_q      <= ptr_nxt;
        done       <= last;
        eot        <= last;
        fetch_pend <= (mode == XF_READ);
      end else begin
        eot        <= 1'b0;
        fetch_pend <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/wbp_ram.sv
module wbp_ram #(
  parameter int DEPTH = 256,
  parameter int WORDS = DEPTH / 2,
  parameter int AW    = $clog2(WORDS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   addr,
  input  logic [1:0]      we,
  input  logic [1:0][7:0] wd,
  output logic [1:0][7:0] q
);
  // Lane 1 holds even byte addresses (word bits 15:8), lane 0 the odd ones.
  for (genvar l = 0; l < 2; l++) begin : g_lane
    logic [7:0] mem [WORDS];
    always_ff @(posedge clk) begin
      if (we[l]) mem[addr] <= wd[l];
    end
    always_ff @(posedge clk) begin
      if (!rst_n) q[l] <= '0;
      else        q[l] <= mem[addr];
    end
  end
endmodule

// File: rtl/wbp_status.sv
module wbp_status #(
  parameter int EOT_BIT = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       eot,
  input  logic       cmd_ok,
  input  logic       irq_we,
  input  logic [7:0] irq_wdata,
  output logic [7:0] irq_status,
  output logic       buf_done
);
  logic irq_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_q    <= 1'b0;
      buf_done <= 1'b0;
    end else begin
      if (eot) irq_q <= 1'b1;
      else if (irq_we && irq_wdata[EOT_BIT]) irq_q <= 1'b0;
      if (cmd_ok)   buf_done <= 1'b0;
      else if (eot) buf_done <= 1'b1;
    end
  end

  always_comb begin
    irq_status          = '0;
    irq_status[EOT_BIT] = irq_q;
  end
endmodule

// File: rtl/wordbuf_port.sv
module wordbuf_port
  import wbp_pkg::*;
#(
  parameter int DEPTH = 256,
  parameter int CW    = $clog2(DEPTH) + 1,
  parameter int AW    = $clog2(DEPTH) - 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cnt_we,
  input  logic [15:0] cnt_wdata,
  input  logic        cmd_we,
  input  logic [7:0]  cmd_code,
  input  logic        wr_valid,
  output logic        wr_ready,
  input  logic [15:0] wr_data,
  output logic        rd_valid,
  input  logic        rd_ready,
  output logic [15:0] rd_data,
  input  logic        irq_we,
  input  logic [7:0]  irq_wdata,
  output logic [7:0]  irq_status,
  output logic        buf_done,
  output logic        eot_pulse
);
  xfer_mode_e      mode;
  logic [CW-1:0]   ptr;
  logic            done, fetch_pend, cmd_ok, we_even, we_odd;
  logic [1:0][7:0] ram_q, ram_wd;

  assign wr_ready = !cmd_we;
  assign rd_valid = (mode == XF_READ) && !fetch_pend;
  assign rd_data  = done ? 16'h0000 : {ram_q[1], ram_q[0]};
  assign ram_wd   = {wr_data[15:8], wr_data[7:0]};

  wbp_ctrl #(.DEPTH(DEPTH), .CW(CW)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .cnt_we(cnt_we), .cnt_wdata(cnt_wdata),
    .cmd_we(cmd_we), .cmd_code(cmd_code),
    .wr_fire(wr_valid && wr_ready), .rd_fire(rd_valid && rd_ready),
    .mode(mode), .ptr(ptr), .done(done), .fetch_pend(fetch_pend),
    .eot(eot_pulse), .cmd_ok(cmd_ok), .we_even(we_even), .we_odd(we_odd)
  );

  wbp_ram #(.DEPTH(DEPTH), .WORDS(DEPTH / 2), .AW(AW)) u_ram (
    .clk(clk), .rst_n(rst_n),
    .addr(ptr[CW-2:1]),
    .we({we_even, we_odd}),
    .wd(ram_wd),
    .q(ram_q)
  );

  wbp_status #(.EOT_BIT(2)) u_status (
    .clk(clk), .rst_n(rst_n),
    .eot(eot_pulse), .cmd_ok(cmd_ok),
    .irq_we(irq_we), .irq_wdata(irq_wdata),
    .irq_status(irq_status), .buf_done(buf_done)
  );
endmodule

// File: rtl/wordbuf_port_chk.sv
module wordbuf_port_chk
  import wbp_pkg::*;
#(
  parameter int CW = 9
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_we,
  input logic [7:0]    cmd_code,
  input logic          wr_valid,
  input logic          rd_valid,
  input logic [15:0]   rd_data,
  input logic          irq_we,
  input logic [7:0]    irq_wdata,
  input logic [7:0]    irq_status,
  input logic          buf_done,
  input logic          eot_pulse,
  input xfer_mode_e    mode,
  input logic [CW-1:0] ptr,
  input logic          done
);
  assert_cmd_ptr_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_we && (cmd_code == 8'h40 || cmd_code == 8'hC0) |=> ptr == '0);

  assert_ptr_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_we && wr_valid && mode == XF_WRITE && !done |=> ptr == $past(ptr) + CW'(2));

  assert_eot_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    eot_pulse && !cmd_we |=> !eot_pulse);

  assert_irq_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    eot_pulse |=> irq_status[2]);

  assert_irq_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_we && irq_wdata[2] && !eot_pulse |=> !irq_status[2]);

  assert_buf_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    eot_pulse && !cmd_we |=> buf_done);

  assert_done_reads_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && done |-> rd_data == 16'h0000);

  assert_fetch_bubble_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_we && cmd_code == 8'h40 |=> !rd_valid);
endmodule

bind wordbuf_port wordbuf_port_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_code(cmd_code),
  .wr_valid(wr_valid), .rd_valid(rd_valid), .rd_data(rd_data),
  .irq_we(irq_we), .irq_wdata(irq_wdata), .irq_status(irq_status),
  .buf_done(buf_done), .eot_pulse(eot_pulse), .mode(mode), .ptr(ptr), .done(done)
);

// File: tb/wordbuf_port_bench.sv
`timescale 1ns/1ps
module wordbuf_port_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cnt_we = 1'b0, cmd_we = 1'b0, wr_valid = 1'b0, rd_ready = 1'b0, irq_we = 1'b0;
  logic [15:0] cnt_wdata = '0, wr_data = '0;
  logic [7:0]  cmd_code = '0, irq_wdata = '0;
  logic        wr_ready, rd_valid, buf_done, eot_pulse;
  logic [15:0] rd_data;
  logic [7:0]  irq_status;
  int total = 0, bad = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  wordbuf_port u_wordbuf_port (
    .clk(clk), .rst_n(rst_n), .cnt_we(cnt_we), .cnt_wdata(cnt_wdata),
    .cmd_we(cmd_we), .cmd_code(cmd_code), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_data(wr_data), .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
    .irq_we(irq_we), .irq_wdata(irq_wdata), .irq_status(irq_status),
    .buf_done(buf_done), .eot_pulse(eot_pulse)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic set_count(input int n);
    cnt_we = 1'b1; cnt_wdata = 16'(n);
    @(negedge clk); cnt_we = 1'b0;
  endtask

  task automatic issue(input logic [7:0] code);
    cmd_we = 1'b1; cmd_code = code;
    @(negedge clk); cmd_we = 1'b0;
  endtask

  task automatic push(input logic [15:0] d);
    wr_valid = 1'b1; wr_data = d;
    @(negedge clk); wr_valid = 1'b0;
  endtask

  task automatic pull(output logic [15:0] d);
    while (!rd_valid) @(negedge clk);
    d = rd_data; rd_ready = 1'b1;
    @(negedge clk); rd_ready = 1'b0;
  endtask

  task automatic clear_irq();
    irq_we = 1'b1; irq_wdata = 8'h04;
    @(negedge clk); irq_we = 1'b0;
  endtask

  task automatic t_reset();
    chk(rd_valid == 1'b0, "R13", "rd_valid", rd_valid, 0);
    chk(irq_status == 8'h00, "R13", "irq_status", irq_status, 0);
    chk(buf_done == 1'b0 && eot_pulse == 1'b0, "R13", "done/eot", {buf_done, eot_pulse}, 0);
    chk(wr_ready == 1'b1, "R13", "wr_ready", wr_ready, 1);
  endtask

  task automatic t_roundtrip();
    logic [15:0] pat [4] = '{16'hA1B2, 16'hC3D4, 16'hE5F6, 16'h0718};
    logic [15:0] d;
    set_count(8);
    issue(8'hC0);
    chk(rd_valid == 1'b0, "R11", "rd_valid in write mode", rd_valid, 0);
    for (int i = 0; i < 3; i++) push(pat[i]);
    chk(eot_pulse == 1'b0, "R5", "eot before last word", eot_pulse, 0);
    push(pat[3]);
    chk(eot_pulse == 1'b1, "R5", "eot after last word", eot_pulse, 1);
    chk(irq_status[2] == 1'b0, "R6", "irq not yet set", irq_status[2], 0);
    @(negedge clk);
    chk(eot_pulse == 1'b0, "R5", "eot one cycle", eot_pulse, 0);
    chk(irq_status == 8'h04, "R6", "irq set", irq_status, 8'h04);
    chk(buf_done == 1'b1, "R7", "buf_done set", buf_done, 1);
    issue(8'h40);
    chk(buf_done == 1'b0, "R7", "buf_done cleared by command", buf_done, 0);
    chk(rd_valid == 1'b0, "R11", "fetch bubble after command", rd_valid, 0);
    for (int i = 0; i < 4; i++) begin
      pull(d);
      chk(d == pat[i], "R3", "read back word", d, pat[i]);
      if (i < 3) chk(rd_valid == 1'b0, "R11", "fetch bubble after read", rd_valid, 0);
    end
    @(negedge clk);
  endtask

  task automatic t_odd_count();
    logic [15:0] d;
    set_count(4); issue(8'hC0); push(16'h1111); push(16'h2222);
    set_count(3); issue(8'hC0); push(16'hAAAA);
    chk(eot_pulse == 1'b0, "R5", "odd count eot early", eot_pulse, 0);
    push(16'hBBCC);
    chk(eot_pulse == 1'b1, "R10", "odd count eot on passing", eot_pulse, 1);
    set_count(4); issue(8'h40);
    pull(d); chk(d == 16'hAAAA, "R4", "word0", d, 16'hAAAA);
    pull(d); chk(d == 16'hBB22, "R10", "only even byte stored (15:8 even)", d, 16'hBB22);
    @(negedge clk);
  endtask

  task automatic t_after_done();
    logic [15:0] d;
    set_count(2); issue(8'hC0); push(16'h5566);
    @(negedge clk);
    push(16'h7788);
    chk(eot_pulse == 1'b0, "R9", "no second eot on write", eot_pulse, 0);
    set_count(4); issue(8'h40);
    pull(d); chk(d == 16'h5566, "R9", "write after done ignored word0", d, 16'h5566);
    pull(d); chk(d == 16'hBB22, "R9", "write after done ignored word1", d, 16'hBB22);
    @(negedge clk);
    chk(rd_valid == 1'b1, "R9", "rd_valid after done", rd_valid, 1);
    pull(d); chk(d == 16'h0000, "R9", "read after done is zero", d, 0);
    chk(eot_pulse == 1'b0, "R9", "no second eot on read", eot_pulse, 0);
  endtask

  task automatic t_short_and_irq();
    chk(irq_status[2] == 1'b1, "R6", "irq sticky", irq_status[2], 1);
    irq_we = 1'b1; irq_wdata = 8'hFB;
    @(negedge clk); irq_we = 1'b0;
    chk(irq_status[2] == 1'b1, "R6", "write 0 keeps irq", irq_status[2], 1);
    clear_irq();
    chk(irq_status == 8'h00, "R6", "write 1 clears irq", irq_status, 0);
    set_count(8); issue(8'hC0); push(16'h0101); push(16'h0202);
    repeat (4) @(negedge clk);
    chk(irq_status == 8'h00 && buf_done == 1'b0, "R8", "short transfer no status",
        {irq_status, 7'd0, buf_done}, 0);
  endtask

  task automatic t_commands();
    logic [15:0] d;
    set_count(4); issue(8'hC0); push(16'h1234);
    issue(8'h41);
    push(16'h5678);
    chk(eot_pulse == 1'b1, "R1", "bad code did not reset pointer", eot_pulse, 1);
    @(negedge clk);
    cmd_we = 1'b1; cmd_code = 8'hC0; wr_valid = 1'b1; wr_data = 16'hDEAD;
    #0.5;
    chk(wr_ready == 1'b0, "R12", "wr_ready low in command cycle", wr_ready, 0);
    @(negedge clk); cmd_we = 1'b0; wr_valid = 1'b0;
    push(16'h0102); push(16'h0304);
    issue(8'h40);
    pull(d); chk(d == 16'h0102, "R12", "command-cycle word discarded", d, 16'h0102);
    pull(d); chk(d == 16'h0304, "R3", "second word", d, 16'h0304);
    @(negedge clk);
    issue(8'h40);
    pull(d); chk(d == 16'h0102, "R1", "new command restarts at 0", d, 16'h0102);
    @(negedge clk);
  endtask

  task automatic t_zero_and_clamp();
    logic [15:0] d;
    bit early;
    clear_irq();
    set_count(0); issue(8'h40);
    chk(eot_pulse == 1'b1, "R5", "zero length eot after command", eot_pulse, 1);
    @(negedge clk);
    chk(rd_valid == 1'b1 && rd_data == 16'h0000, "R9", "zero length read", rd_data, 0);
    set_count(300); issue(8'hC0);
    early = 1'b0;
    for (int i = 0; i < 128; i++) begin
      push(16'(i * 257 + 3));
      if (i < 127 && eot_pulse) early = 1'b1;
    end
    chk(!early, "R2", "no eot before 256 bytes", early, 0);
    chk(eot_pulse == 1'b1, "R2", "clamped length eot at 256", eot_pulse, 1);
    set_count(256); issue(8'h40);
    pull(d); chk(d == 16'h0003, "R2", "clamp word0", d, 16'h0003);
    for (int i = 1; i < 127; i++) pull(d);
    pull(d); chk(d == 16'(127 * 257 + 3), "R2", "clamp last word", d, 16'(127 * 257 + 3));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_roundtrip();
    t_odd_count();
    t_after_done();
    t_short_and_irq();
    t_commands();
    t_zero_and_clamp();
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule